// File: doc/BRIEF.md
# Five-Slot Rotating Pipeline Sequencer

This block sequences instructions through a five-stage processor pipeline. The stages are fetch, decode, execute, memory and write-back. The pipeline is not built from fixed registers between stages. Instead it uses five identical slot state machines arranged in a ring. Each slot carries one instruction through every stage, one stage per clock.

A slot that is fetching starts its successor fetching on the next clock. Once filled, the ring therefore keeps all five stages busy, and no two slots ever share a stage. Slots are numbered 0 to 4, and slot 0 is the one that comes out of reset fetching.

The surrounding datapath uses the outputs in two ways:
- It reads the per-slot stage codes and the per-stage owner vectors to steer its own resources.
- It uses the memory-write and write-back permissions to block side effects from instructions that have been squashed, for example after a branch that was guessed wrong.

A global stall freezes the whole ring.

Top module: `seq_ring`

## Requirements
- R1: While `rst_n` is low, slot 0 is in fetch, slots 1 to 4 are idle, and every kill flag is 0.
- R2: Slot s reports its stage in `slot_stage[3*s+2:3*s]`. The codes are idle=0, fetch=1, decode=2, execute=3, memory=4 and write-back=5.
- R3: On a clock edge with `stall` low, a slot that was in fetch makes its ring successor enter fetch: slot s starts slot (s+1) mod 5, so slot 4 starts slot 0. Being started takes priority over a slot's own advance.
- R4: On a clock edge with `stall` low, a slot that is not being started advances one stage: fetch→decode→execute→memory→write-back→idle. An idle slot that is not being started stays idle.
- R5: `stage_owner[5*k+s]` is 1 exactly when slot s is in stage k, where k is 0 for fetch, 1 decode, 2 execute, 3 memory and 4 write-back. Each stage has at most one owner.
- R6: On a clock edge with `stall` high, every slot keeps its stage and no slot is started.
- R7: On a clock edge where `squash[s]` is high and slot s is not idle, `slot_killed[s]` becomes 1. The flag stays 1 until the edge at which the slot is started into fetch, which clears it; clearing wins over a squash on that same edge. A squash aimed at an idle slot has no effect.
- R8: `mem_wr_en` is 1 exactly when some slot is in memory and its kill flag is 0. `wb_wr_en` is defined the same way for write-back.
- R9: A squash on a clock edge with `stall` high still sets the kill flag of a non-idle slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stall | input | 1 | Freezes all slots and blocks new fetch starts |
| squash | input | 5 | Per-slot kill request |
| slot_stage | output | 15 | Three-bit stage code for each slot |
| stage_owner | output | 25 | Five one-hot-or-zero slot vectors, one for each stage |
| slot_killed | output | 5 | Per-slot kill flag |
| mem_wr_en | output | 1 | Memory write permitted for the slot in the memory stage |
| wb_wr_en | output | 1 | Register write permitted for the slot in the write-back stage |

## Verification
The hardest situation to reach is a kill flag that must be cleared exactly as its slot wraps from write-back back to fetch, especially while a new squash arrives on that same edge or while the ring is stalled. The bench reaches it by counting unstalled edges from reset. That count fixes which slot holds which stage, so squashes can be aimed at a chosen slot in a chosen stage, including the write-back cycle just before the restart and cycles inside a stall. Squashes aimed at slots that have not yet started are driven during the fill phase. Their lack of effect then shows on the write enables once those slots reach memory and write-back.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NUM_STAGES = 5;
  localparam int STAGE_W    = 3;

  typedef enum logic [STAGE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_IF   = 3'd1,
    ST_ID   = 3'd2,
    ST_EX   = 3'd3,
    ST_MEM  = 3'd4,
    ST_WB   = 3'd5
  } stage_e;

  // Successor stage for a slot that is not being started.
  function automatic stage_e advance(input stage_e cur);
    case (cur)
      ST_IF:   advance = ST_ID;
      ST_ID:   advance = ST_EX;
      ST_EX:   advance = ST_MEM;
      ST_MEM:  advance = ST_WB;
      default: advance = ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/seq_slot.sv
module seq_slot
  import seq_pkg::*;
#(
  parameter bit IS_FIRST = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stall,
  input  logic   start,
  input  logic   squash,
  output stage_e stage,
  output logic   killed
);
  localparam stage_e RESET_STAGE = IS_FIRST ? ST_IF : ST_IDLE;

  stage_e stage_q, stage_d;
  logic   killed_q, killed_d;
  logic   stage_en;
  logic   take_start;

  assign stage_en   = !stall;
  assign take_start = start && !stall;

  always_comb begin
    stage_d = take_start ? ST_IF : advance(stage_q);
  end

  always_comb begin
    killed_d = killed_q;
    if (take_start) begin
      killed_d = 1'b0;
    end else if (squash && (stage_q != ST_IDLE)) begin
      killed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= RESET_STAGE;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      killed_q <= 1'b0;
    end else begin
      killed_q <= killed_d;
    end
  end

  assign stage  = stage_q;
  assign killed = killed_q;
endmodule

// File: rtl/seq_owner_map.sv
module seq_owner_map
  import seq_pkg::*;
#(
  parameter int NUM_SLOTS = 5
) (
  input  logic [NUM_SLOTS*STAGE_W-1:0]    stages,
  output logic [NUM_STAGES*NUM_SLOTS-1:0] owner
);
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign owner[k*NUM_SLOTS+s] =
        (stages[s*STAGE_W +: STAGE_W] == STAGE_W'(k + 1));
    end
  end
endmodule

// File: rtl/seq_wr_gate.sv
module seq_wr_gate
  import seq_pkg::*;
#(
  parameter int NUM_SLOTS = 5
) (
  input  logic [NUM_STAGES*NUM_SLOTS-1:0] owner,
  input  logic [NUM_SLOTS-1:0]            killed,
  output logic                            mem_wr_en,
  output logic                            wb_wr_en
);
  localparam int MEM_ROW = int'(ST_MEM) - 1;
  localparam int WB_ROW  = int'(ST_WB) - 1;

  assign mem_wr_en = |(owner[MEM_ROW*NUM_SLOTS +: NUM_SLOTS] & ~killed);
  assign wb_wr_en  = |(owner[WB_ROW*NUM_SLOTS +: NUM_SLOTS] & ~killed);
endmodule

// File: rtl/seq_ring.sv
module seq_ring
  import seq_pkg::*;
#(
  parameter int NUM_SLOTS = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 stall,
  input  logic [NUM_SLOTS-1:0]                 squash,
  output logic [NUM_SLOTS*STAGE_W-1:0]         slot_stage,
  output logic [NUM_STAGES*NUM_SLOTS-1:0]      stage_owner,
  output logic [NUM_SLOTS-1:0]                 slot_killed,
  output logic                                 mem_wr_en,
  output logic                                 wb_wr_en
);
  stage_e               stage_w [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] start_w;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int PREV = (s + NUM_SLOTS - 1) % NUM_SLOTS;

    assign start_w[s] = (stage_w[PREV] == ST_IF);

    seq_slot #(.IS_FIRST(s == 0)) i_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .stall  (stall),
      .start  (start_w[s]),
      .squash (squash[s]),
      .stage  (stage_w[s]),
      .killed (slot_killed[s])
    );

    assign slot_stage[s*STAGE_W +: STAGE_W] = stage_w[s];
  end

  seq_owner_map #(.NUM_SLOTS(NUM_SLOTS)) i_owner (
    .stages (slot_stage),
    .owner  (stage_owner)
  );

  seq_wr_gate #(.NUM_SLOTS(NUM_SLOTS)) i_gate (
    .owner     (stage_owner),
    .killed    (slot_killed),
    .mem_wr_en (mem_wr_en),
    .wb_wr_en  (wb_wr_en)
  );
endmodule

// File: rtl/seq_ring_chk.sv
module seq_ring_chk
  import seq_pkg::*;
#(
  parameter int NUM_SLOTS = 5
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            stall,
  input logic [NUM_SLOTS-1:0]            squash,
  input logic [NUM_SLOTS*STAGE_W-1:0]    slot_stage,
  input logic [NUM_STAGES*NUM_SLOTS-1:0] stage_owner,
  input logic [NUM_SLOTS-1:0]            slot_killed,
  input logic                            mem_wr_en,
  input logic                            wb_wr_en
);
  localparam int MEM_ROW = int'(ST_MEM) - 1;
  localparam int WB_ROW  = int'(ST_WB) - 1;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stage_owner[k*NUM_SLOTS +: NUM_SLOTS])); // R5
  end

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(slot_stage)); // R6

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int NEXT = (s + 1) % NUM_SLOTS;
    localparam int PREV = (s + NUM_SLOTS - 1) % NUM_SLOTS;

    AST_FETCH_STARTS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && slot_stage[s*STAGE_W +: STAGE_W] == ST_IF)
      |=> slot_stage[NEXT*STAGE_W +: STAGE_W] == ST_IF); // R3

    AST_EX_TO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && slot_stage[s*STAGE_W +: STAGE_W] == ST_EX)
      |=> slot_stage[s*STAGE_W +: STAGE_W] == ST_MEM); // R4

    AST_KILL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (squash[s] && slot_stage[s*STAGE_W +: STAGE_W] != ST_IDLE &&
       !(!stall && slot_stage[PREV*STAGE_W +: STAGE_W] == ST_IF))
      |=> slot_killed[s]); // R7

    AST_KILLED_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_killed[s] && stage_owner[MEM_ROW*NUM_SLOTS+s]) |-> !mem_wr_en); // R8

    AST_KILLED_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_killed[s] && stage_owner[WB_ROW*NUM_SLOTS+s]) |-> !wb_wr_en); // R8
  end
endmodule

bind seq_ring seq_ring_chk #(.NUM_SLOTS(NUM_SLOTS)) i_chk (.*);

// File: tb/test_seq_ring.sv
module test_seq_ring;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;

  logic        clk;
  logic        rst_n;
  logic        stall;
  logic [4:0]  squash;
  logic [14:0] slot_stage;
  logic [24:0] stage_owner;
  logic [4:0]  slot_killed;
  logic        mem_wr_en;
  logic        wb_wr_en;

  int checks = 0;
  int fails  = 0;
  int t_run  = 0;          // unstalled edges since reset release
  logic [4:0] kill_m;      // bench model of kill flags

  seq_ring i_seq_ring (
    .clk(clk), .rst_n(rst_n), .stall(stall), .squash(squash),
    .slot_stage(slot_stage), .stage_owner(stage_owner),
    .slot_killed(slot_killed), .mem_wr_en(mem_wr_en), .wb_wr_en(wb_wr_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Stage code of slot s after t unstalled edges: R2/R3/R4
  function automatic logic [2:0] exp_stage(int s, int t);
    if (t < s) return 3'd0;
    return 3'((t - s) % 5 + 1);
  endfunction

  function automatic logic [14:0] exp_stages(int t);
    logic [14:0] v = '0;
    for (int s = 0; s < N; s++) v[3*s +: 3] = exp_stage(s, t);
    return v;
  endfunction

  function automatic logic [24:0] exp_owner(int t);
    logic [24:0] v = '0;
    for (int s = 0; s < N; s++) begin
      logic [2:0] st = exp_stage(s, t);
      if (st != 3'd0) v[5*(int'(st)-1) + s] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic exp_wr(int t, logic [4:0] km, logic [2:0] code);
    for (int s = 0; s < N; s++)
      if (exp_stage(s, t) == code && !km[s]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (t=%0d)", tag, what, act, exp, t_run);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "slot_stage", 32'(slot_stage), 32'(exp_stages(t_run)));
    chk(tag, "stage_owner", 32'(stage_owner), 32'(exp_owner(t_run)));
    chk(tag, "slot_killed", 32'(slot_killed), 32'(kill_m));
    chk(tag, "mem_wr_en", 32'(mem_wr_en), 32'(exp_wr(t_run, kill_m, 3'd4)));
    chk(tag, "wb_wr_en", 32'(wb_wr_en), 32'(exp_wr(t_run, kill_m, 3'd5)));
  endtask

  // Drive one cycle at the falling edge, update the model, check at next falling edge.
  task automatic tick(logic st, logic [4:0] sq, string tag);
    stall  = st;
    squash = sq;
    @(posedge clk);
    for (int s = 0; s < N; s++) begin
      logic started = !st && exp_stage((s + N - 1) % N, t_run) == 3'd1;
      if (started) kill_m[s] = 1'b0;
      else if (sq[s] && exp_stage(s, t_run) != 3'd0) kill_m[s] = 1'b1;
    end
    if (!st) t_run++;
    @(negedge clk);
    stall  = 1'b0;
    squash = '0;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stall = 1'b0; squash = '0;
    t_run = 0; kill_m = '0;
    #(CLK_PERIOD*2);
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
  endtask

  task automatic t_fill();
    for (int i = 0; i < 14; i++) tick(1'b0, '0, "R2 R3 R4 R5 R8");
  endtask

  task automatic t_stall();
    for (int i = 0; i < 3; i++) tick(1'b1, '0, "R6");
    for (int i = 0; i < 2; i++) tick(1'b0, '0, "R6 R3");
  endtask

  task automatic t_squash_ex();
    // find the slot in execute, kill it, watch memory and write-back
    int victim = 0;
    for (int s = 0; s < N; s++) if (exp_stage(s, t_run) == 3'd3) victim = s;
    tick(1'b0, 5'(1 << victim), "R7");
    for (int i = 0; i < 6; i++) tick(1'b0, '0, "R7 R8");
  endtask

  task automatic t_squash_wb_restart();
    // squash the slot in write-back on the edge that restarts it: clear wins
    int victim = 0;
    for (int s = 0; s < N; s++) if (exp_stage(s, t_run) == 3'd5) victim = s;
    tick(1'b0, 5'(1 << victim), "R7");
    for (int i = 0; i < 5; i++) tick(1'b0, '0, "R7 R8");
  endtask

  task automatic t_squash_idle();
    do_reset();
    tick(1'b0, 5'b11100, "R7");
    tick(1'b0, 5'b11000, "R7");
    tick(1'b0, 5'b10000, "R7");
    for (int i = 0; i < 9; i++) tick(1'b0, '0, "R7 R8");
  endtask

  task automatic t_stall_squash();
    int victim = 0;
    for (int s = 0; s < N; s++) if (exp_stage(s, t_run) == 3'd2) victim = s;
    tick(1'b1, 5'(1 << victim), "R9");
    tick(1'b1, '0, "R9 R6");
    for (int i = 0; i < 6; i++) tick(1'b0, '0, "R9 R8");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; stall = 1'b0; squash = '0; kill_m = '0;
    do_reset();
    t_fill();
    t_stall();
    t_squash_ex();
    t_squash_wb_restart();
    t_stall_squash();
    t_squash_idle();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD*20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule